// File: doc/BRIEF.md
# Sequential Fetch Burst Tracker

This block watches the instruction-fetch side of a processor bus, one cycle per clock. Each cycle carries a declared type (nonsequential, sequential, internal or idle), an address, an access width and two attribute fields: direction and protection. From that stream the tracker keeps a record of whether a fetch burst is open, which address the next sequential fetch must present, and how many beats the burst has delivered so far.

A memory controller uses its outputs to skip the address phase. `burst_continue` means the current beat follows on in the open burst, so a row or page can stay open. `new_burst` marks where a fresh burst begins. The saturating `beat_num` lets the controller split a long burst at a row boundary. Protocol violations raise one error strobe each and close the burst. Those violations are a byte-wide sequential fetch, a change of attributes within a burst, a wrong address, and a sequential cycle that nothing opened.

An internal cycle followed at once by a sequential cycle at the same address, with the same attributes, is a merged burst start. It is accepted as the opening of a burst, not as a mismatch. All strobes are registered: they describe the cycle presented on the previous rising edge.

Top module: `fetch_burst_tracker`

## Requirements
- R1: The cycle type is encoded 00 = nonsequential, 01 = sequential, 10 = internal, 11 = idle. A nonsequential cycle opens a burst. One clock later `new_burst` pulses, `burst_active` is 1, `beat_num` is 1, and `next_addr` holds the presented address plus the step.
- R2: A sequential cycle in an open burst continues the burst when its address equals `next_addr` and its width, direction and protection equal those of the opening cycle. Both `burst_continue` and `seq_hit` then pulse, and `next_addr` advances by one step.
- R3: The step is set by the width code: 01 (halfword, compressed instruction set) steps by 2. Every other code, including 10 (word), steps by 4. Address arithmetic wraps modulo 2^AW.
- R4: A sequential cycle with width code 00 (byte) raises `size_err` and closes the burst. This check takes priority over all other sequential checks.
- R5: A sequential cycle in an open burst whose width, direction or protection differ from the opening cycle raises `attr_err` and closes the burst.
- R6: A sequential cycle in an open burst with the right attributes but an address other than `next_addr` raises `addr_err` and closes the burst. `next_addr` is left unchanged.
- R7: Consider a sequential cycle that directly follows an internal cycle and repeats that cycle's address and attributes. It is a merged start: `new_burst` and `seq_hit` pulse, no error strobe is raised, `beat_num` is 1, and `next_addr` is that address plus the step.
- R8: A sequential cycle with no open burst that is not a merged start raises `order_err`, and the burst stays closed.
- R9: After a single internal cycle, the burst stays open for one more cycle, so a matching sequential cycle continues it. A second internal cycle in a row closes the burst. An idle cycle closes the burst.
- R10: `beat_num` counts beats of the current burst and saturates at 255.
- R11: After reset every strobe is 0, `burst_active` is 0, `next_addr` is 0 and `beat_num` is 0.
- R12: At most one of `new_burst`, `burst_continue`, `size_err`, `attr_err`, `addr_err` and `order_err` is high in any cycle. Each is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_type | input | 2 | Bus cycle type: 00 N, 01 S, 10 I, 11 idle |
| fetch_addr | input | AW | Fetch byte address |
| fetch_size | input | 2 | Access width: 00 byte, 01 halfword, 10 word |
| fetch_wr | input | 1 | Direction attribute |
| fetch_prot | input | PW | Protection attribute |
| new_burst | output | 1 | A burst started on the previous cycle |
| burst_continue | output | 1 | Previous cycle was a valid continuing beat |
| seq_hit | output | 1 | Previous sequential address matched its prediction |
| size_err | output | 1 | Byte-wide sequential fetch |
| attr_err | output | 1 | Attribute change inside a burst |
| addr_err | output | 1 | Sequential address mismatch |
| order_err | output | 1 | Sequential cycle with no burst to join |
| burst_active | output | 1 | A burst is open |
| next_addr | output | AW | Predicted address of the next sequential beat |
| beat_num | output | CW | Beat count of the current burst, saturating |

## Verification
The case hardest to reach from the ports is the saturated beat counter. It needs more than 255 consecutive correct sequential beats with no stray cycle in between. Random traffic almost never produces that, so a directed run feeds 300 halfword beats at the predicted addresses and checks the count holding at 255. Merged starts and second-internal closures are also rare by chance, so the random sweep draws the address from the last internal address a fifth of the time. Directed sequences also hit both merged starts and second-internal closures exactly, in both step widths.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

  typedef enum logic [1:0] {
    CYC_NSEQ = 2'b00,
    CYC_SEQ  = 2'b01,
    CYC_INT  = 2'b10,
    CYC_IDLE = 2'b11
  } cyc_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  typedef enum logic [2:0] {
    D_NONE,
    D_OPEN,
    D_MERGE,
    D_CONT,
    D_SIZE,
    D_ATTR,
    D_ADDR,
    D_ORDER
  } dec_e;

  // byte distance between consecutive fetches of a given width
  function automatic logic [2:0] fetch_step(input logic [1:0] sz);
    return (sz == SZ_HALF) ? 3'd2 : 3'd4;
  endfunction

endpackage

// File: rtl/fbt_decide.sv
module fbt_decide
  import fbt_pkg::*;
#(
  parameter int AW = 32,
  parameter int AT = 5
) (
  input  logic [1:0]    cyc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AT-1:0] attr_i,
  input  logic          active_i,
  input  logic [AW-1:0] pred_i,
  input  logic [AT-1:0] cap_i,
  input  logic          ipend_i,
  input  logic [AW-1:0] iaddr_i,
  input  logic [AT-1:0] iattr_i,
  output dec_e          dec_o
);

  logic [1:0] size_w;
  logic       merge_ok;

  assign size_w   = attr_i[AT-1 -: 2];
  assign merge_ok = ipend_i && (addr_i == iaddr_i) && (attr_i == iattr_i);

  always_comb begin
    dec_o = D_NONE;
    case (cyc_i)
      CYC_NSEQ: dec_o = D_OPEN;
      CYC_SEQ: begin
        if (size_w == SZ_BYTE)      dec_o = D_SIZE;
        else if (merge_ok)          dec_o = D_MERGE;
        else if (!active_i)         dec_o = D_ORDER;
        else if (attr_i != cap_i)   dec_o = D_ATTR;
        else if (addr_i != pred_i)  dec_o = D_ADDR;
        else                        dec_o = D_CONT;
      end
      default: dec_o = D_NONE;
    endcase
  end

endmodule

// File: rtl/fbt_track.sv
module fbt_track
  import fbt_pkg::*;
#(
  parameter int AW = 32,
  parameter int AT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cyc_i,
  input  dec_e          dec_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AT-1:0] attr_i,
  output logic          active_o,
  output logic [AW-1:0] pred_o,
  output logic [AT-1:0] cap_o,
  output logic          ipend_o,
  output logic [AW-1:0] iaddr_o,
  output logic [AT-1:0] iattr_o
);

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] base,
                                            input logic [1:0] sz);
    return base + AW'(fetch_step(sz));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      pred_o   <= '0;
      cap_o    <= '0;
      ipend_o  <= 1'b0;
      iaddr_o  <= '0;
      iattr_o  <= '0;
    end else begin
      ipend_o <= (cyc_i == CYC_INT);
      case (dec_i)
        D_OPEN, D_MERGE: begin
          active_o <= 1'b1;
          pred_o   <= advance(addr_i, attr_i[AT-1 -: 2]);
          cap_o    <= attr_i;
        end
        D_CONT: pred_o <= advance(pred_o, cap_o[AT-1 -: 2]);
        D_SIZE, D_ATTR, D_ADDR, D_ORDER: active_o <= 1'b0;
        default: ;
      endcase
      if (cyc_i == CYC_INT) begin
        active_o <= active_o & ~ipend_o;
        iaddr_o  <= addr_i;
        iattr_o  <= attr_i;
      end
      if (cyc_i == CYC_IDLE) active_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fbt_beat.sv
module fbt_beat
  import fbt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dec_e          dec_i,
  output logic [CW-1:0] beat_o
);

  localparam logic [CW-1:0] BEAT_MAX = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_next(input logic [CW-1:0] v);
    return (v == BEAT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                                   beat_o <= '0;
    else if (dec_i == D_OPEN || dec_i == D_MERGE) beat_o <= CW'(1);
    else if (dec_i == D_CONT)                     beat_o <= sat_next(beat_o);
  end

endmodule

// File: rtl/fetch_burst_tracker.sv
module fetch_burst_tracker
  import fbt_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 2,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cyc_type,
  input  logic [AW-1:0] fetch_addr,
  input  logic [1:0]    fetch_size,
  input  logic          fetch_wr,
  input  logic [PW-1:0] fetch_prot,
  output logic          new_burst,
  output logic          burst_continue,
  output logic          seq_hit,
  output logic          size_err,
  output logic          attr_err,
  output logic          addr_err,
  output logic          order_err,
  output logic          burst_active,
  output logic [AW-1:0] next_addr,
  output logic [CW-1:0] beat_num
);

  localparam int AT = 3 + PW;

  logic [AT-1:0] attr_w;
  logic [AT-1:0] cap_q, iattr_q;
  logic [AW-1:0] iaddr_q;
  logic          ipend_q;
  dec_e          dec_w;

  // named events for the checker
  logic ev_open, ev_merge, ev_cont, ev_fault;

  assign attr_w = {fetch_size, fetch_wr, fetch_prot};

  fbt_decide #(.AW(AW), .AT(AT)) u_decide (
    .cyc_i(cyc_type), .addr_i(fetch_addr), .attr_i(attr_w),
    .active_i(burst_active), .pred_i(next_addr), .cap_i(cap_q),
    .ipend_i(ipend_q), .iaddr_i(iaddr_q), .iattr_i(iattr_q),
    .dec_o(dec_w)
  );

  fbt_track #(.AW(AW), .AT(AT)) u_track (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc_type), .dec_i(dec_w),
    .addr_i(fetch_addr), .attr_i(attr_w),
    .active_o(burst_active), .pred_o(next_addr), .cap_o(cap_q),
    .ipend_o(ipend_q), .iaddr_o(iaddr_q), .iattr_o(iattr_q)
  );

  fbt_beat #(.CW(CW)) u_beat (
    .clk(clk), .rst_n(rst_n), .dec_i(dec_w), .beat_o(beat_num)
  );

  assign ev_open  = (dec_w == D_OPEN);
  assign ev_merge = (dec_w == D_MERGE);
  assign ev_cont  = (dec_w == D_CONT);
  assign ev_fault = (dec_w == D_SIZE) || (dec_w == D_ATTR) ||
                    (dec_w == D_ADDR) || (dec_w == D_ORDER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_burst      <= 1'b0;
      burst_continue <= 1'b0;
      seq_hit        <= 1'b0;
      size_err       <= 1'b0;
      attr_err       <= 1'b0;
      addr_err       <= 1'b0;
      order_err      <= 1'b0;
    end else begin
      new_burst      <= ev_open | ev_merge;
      burst_continue <= ev_cont;
      seq_hit        <= ev_cont | ev_merge;
      size_err       <= (dec_w == D_SIZE);
      attr_err       <= (dec_w == D_ATTR);
      addr_err       <= (dec_w == D_ADDR);
      order_err      <= (dec_w == D_ORDER);
    end
  end

endmodule

// File: rtl/fbt_checker.sv
module fbt_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cyc_type,
  input logic          ev_fault,
  input logic          new_burst,
  input logic          burst_continue,
  input logic          seq_hit,
  input logic          size_err,
  input logic          attr_err,
  input logic          addr_err,
  input logic          order_err,
  input logic          burst_active,
  input logic [CW-1:0] beat_num
);

  logic any_err;
  assign any_err = size_err | attr_err | addr_err | order_err;

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({new_burst, burst_continue, size_err, attr_err, addr_err, order_err}));

  assert_open_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    new_burst |-> (burst_active && beat_num == CW'(1)));

  assert_nseq_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'b00) |=> new_burst);

  assert_cont_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_continue |-> (seq_hit && burst_active));

  assert_error_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |-> !burst_active);

  assert_fault_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> any_err);

  assert_idle_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'b11) |=> (!burst_active && !new_burst));

  assert_beat_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_continue |-> (beat_num == (($past(beat_num) == {CW{1'b1}}) ?
                                     $past(beat_num) : $past(beat_num) + 1'b1)));

endmodule

bind fetch_burst_tracker fbt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .ev_fault(ev_fault),
  .new_burst(new_burst), .burst_continue(burst_continue), .seq_hit(seq_hit),
  .size_err(size_err), .attr_err(attr_err), .addr_err(addr_err),
  .order_err(order_err), .burst_active(burst_active), .beat_num(beat_num)
);

// File: tb/sim_fetch_burst_tracker.sv
`timescale 1ns/1ps
module sim_fetch_burst_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cyc_type = 2'b11;
  logic [31:0] fetch_addr = '0;
  logic [1:0]  fetch_size = 2'b10;
  logic        fetch_wr = 1'b0;
  logic [1:0]  fetch_prot = 2'b10;
  logic        new_burst, burst_continue, seq_hit;
  logic        size_err, attr_err, addr_err, order_err, burst_active;
  logic [31:0] next_addr;
  logic [7:0]  beat_num;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic        m_act = 0, m_ipend = 0;
  logic [31:0] m_pred = 0, m_iaddr = 0;
  logic [4:0]  m_cap = 0, m_iattr = 0;
  logic [7:0]  m_beat = 0;
  logic        e_new, e_cont, e_hit, e_sz, e_at, e_ad, e_or;

  always #2 clk = ~clk;

  fetch_burst_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .fetch_addr(fetch_addr),
    .fetch_size(fetch_size), .fetch_wr(fetch_wr), .fetch_prot(fetch_prot),
    .new_burst(new_burst), .burst_continue(burst_continue), .seq_hit(seq_hit),
    .size_err(size_err), .attr_err(attr_err), .addr_err(addr_err),
    .order_err(order_err), .burst_active(burst_active),
    .next_addr(next_addr), .beat_num(beat_num)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] stp(input logic [1:0] sz);
    if (sz == 2'b01) return 32'd2;
    return 32'd4;
  endfunction

  task automatic apply(input logic [1:0] t, input logic [31:0] a,
                       input logic [1:0] sz, input logic wr, input logic [1:0] pr);
    logic [4:0] at;
    int strobes;
    at = {sz, wr, pr};
    @(negedge clk);
    cyc_type = t; fetch_addr = a; fetch_size = sz; fetch_wr = wr; fetch_prot = pr;
    {e_new, e_cont, e_hit, e_sz, e_at, e_ad, e_or} = '0;
    if (t == 2'b00) begin
      e_new = 1; m_act = 1; m_pred = a + stp(sz); m_cap = at; m_beat = 1;
    end else if (t == 2'b01) begin
      if (sz == 2'b00) begin e_sz = 1; m_act = 0; end
      else if (m_ipend && a == m_iaddr && at == m_iattr) begin
        e_new = 1; e_hit = 1; m_act = 1; m_pred = a + stp(sz); m_cap = at; m_beat = 1;
      end
      else if (!m_act) e_or = 1;
      else if (at != m_cap) begin e_at = 1; m_act = 0; end
      else if (a != m_pred) begin e_ad = 1; m_act = 0; end
      else begin
        e_cont = 1; e_hit = 1; m_pred = m_pred + stp(m_cap[4:3]);
        if (m_beat != 8'd255) m_beat = m_beat + 8'd1;
      end
    end else if (t == 2'b10) begin
      m_act = m_act && !m_ipend; m_iaddr = a; m_iattr = at;
    end else m_act = 0;
    m_ipend = (t == 2'b10);
    @(posedge clk); #1;
    chk("R1", "new_burst", new_burst, e_new);
    chk("R2", "burst_continue", burst_continue, e_cont);
    chk("R2", "seq_hit", seq_hit, e_hit);
    chk("R4", "size_err", size_err, e_sz);
    chk("R5", "attr_err", attr_err, e_at);
    chk("R6", "addr_err", addr_err, e_ad);
    chk("R8", "order_err", order_err, e_or);
    chk("R9", "burst_active", burst_active, m_act);
    chk("R3", "next_addr", next_addr, m_pred);
    chk("R10", "beat_num", beat_num, m_beat);
    strobes = new_burst + burst_continue + size_err + attr_err + addr_err + order_err;
    chk("R12", "strobe count <= 1", (strobes <= 1), 1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset active", burst_active, 0);
    chk("R11", "reset next_addr", next_addr, 0);
    chk("R11", "reset beat", beat_num, 0);
    chk("R11", "reset strobes",
        {new_burst, burst_continue, seq_hit, size_err, attr_err, addr_err, order_err}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3: word and halfword bursts, plus wrap
    apply(2'b00, 32'h100, 2'b10, 0, 2'b10);
    apply(2'b01, 32'h104, 2'b10, 0, 2'b10);
    apply(2'b01, 32'h108, 2'b10, 0, 2'b10);
    apply(2'b00, 32'h200, 2'b01, 0, 2'b10);
    apply(2'b01, 32'h202, 2'b01, 0, 2'b10);
    apply(2'b00, 32'hFFFF_FFFC, 2'b10, 0, 2'b10);
    chk("R3", "wrapped prediction", next_addr, 32'h0);
    apply(2'b01, 32'h0, 2'b10, 0, 2'b10);
    // R4 byte sequential
    apply(2'b01, 32'h4, 2'b00, 0, 2'b10);
    // R5 attribute changes
    apply(2'b00, 32'h300, 2'b10, 0, 2'b10);
    apply(2'b01, 32'h304, 2'b10, 1, 2'b10);
    apply(2'b00, 32'h300, 2'b10, 0, 2'b10);
    apply(2'b01, 32'h304, 2'b10, 0, 2'b11);
    // R6 address mismatch
    apply(2'b00, 32'h300, 2'b10, 0, 2'b10);
    apply(2'b01, 32'h308, 2'b10, 0, 2'b10);
    chk("R6", "prediction held", next_addr, 32'h304);
    // R7 merged starts in both widths
    apply(2'b10, 32'h400, 2'b01, 0, 2'b10);
    apply(2'b01, 32'h400, 2'b01, 0, 2'b10);
    chk("R7", "merged start no error", {new_burst, seq_hit, addr_err, order_err}, 4'b1100);
    apply(2'b01, 32'h402, 2'b01, 0, 2'b10);
    apply(2'b10, 32'h500, 2'b10, 0, 2'b10);
    apply(2'b01, 32'h500, 2'b10, 0, 2'b10);
    chk("R7", "merged word beat", beat_num, 8'd1);
    // R9 single internal keeps burst, double closes, idle closes
    apply(2'b10, 32'h900, 2'b10, 0, 2'b10);
    apply(2'b01, 32'h504, 2'b10, 0, 2'b10);
    apply(2'b10, 32'h900, 2'b10, 0, 2'b10);
    apply(2'b10, 32'h904, 2'b10, 0, 2'b10);
    apply(2'b01, 32'h508, 2'b10, 0, 2'b10);
    apply(2'b00, 32'h600, 2'b10, 0, 2'b10);
    apply(2'b11, 32'h0, 2'b10, 0, 2'b10);
    // R8 orphan sequential
    apply(2'b01, 32'h604, 2'b10, 0, 2'b10);
    // R10 saturation over 300 halfword beats
    apply(2'b00, 32'h1000, 2'b01, 0, 2'b10);
    for (int i = 0; i < 300; i++) apply(2'b01, m_pred, 2'b01, 0, 2'b10);
    chk("R10", "saturated beat", beat_num, 8'd255);

    // random sweep, both widths
    for (int mode = 0; mode < 2; mode++) begin
      logic [1:0] msz;
      msz = (mode == 0) ? 2'b01 : 2'b10;
      for (int k = 0; k < 3000; k++) begin
        logic [1:0] t, sz, pr;
        logic [31:0] a;
        logic wr;
        int r, p, q;
        r = $urandom % 100; p = $urandom % 10; q = $urandom % 100;
        t = (r < 10) ? 2'b00 : (r < 70) ? 2'b01 : (r < 85) ? 2'b10 : 2'b11;
        a = (p < 6) ? m_pred : (p < 8) ? m_iaddr : ($urandom & 32'hFFFF_FFFE);
        sz = (q < 90) ? msz : (q < 95) ? 2'b00 : ~msz;
        wr = (($urandom % 100) < 3);
        pr = (($urandom % 100) < 95) ? 2'b10 : 2'($urandom);
        apply(t, a, sz, wr, pr);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule